// File: doc/BRIEF.md
# Dual-Reset Configuration Control Register

This block is an 8-bit control register on a processor-side register bus. It keeps the settings for two external bus access windows (a 32-bit addressing window and a low-memory page window), the display controller enable, a general-purpose output, and the bus arbitration settings (request level, release mode, arbitration scheme). A write happens on the clock edge where the address-hit and write strobe inputs are both high. The read data port always shows the stored contents.

Two synchronous, active-high resets act on the register. The power-on reset clears every bit. The warm reset, raised by a push button, a watchdog or a system reset, clears only the low nibble and leaves the arbitration settings as they are. The display enable is sticky: software can set it but cannot clear it, and only a reset clears it. An external bus event input masks both window enables at the outputs without changing what is stored. The priority arbitration output only takes effect when a slot-1 strap input is high.

Top module: `cfg_ctrl_reg`

## Requirements
- R1: On a clock edge with `reg_sel` and `reg_wr` both high and no reset, bits [7:3] and [1:0] take the value of `reg_wdata`. Without both strobes high the register keeps its value.
- R2: A warm reset (`warm_rst` high, `por_rst` low) clears bits [3:0] and leaves bits [7:4] unchanged.
- R3: A power-on reset (`por_rst` high) clears all eight bits, and it takes priority over `warm_rst` and over a write in the same cycle.
- R4: Bit [2] (display enable) is set when a write has bit 2 = 1. A write with bit 2 = 0 leaves it as it is, and only a reset clears it. `disp_en` follows bit [2].
- R5: `gpo_n` always drives the inverse of bit [3].
- R6: `win32_en` equals bit [0] and `epage_en` equals bit [1] while `bus_event` is low. Both are 0 while `bus_event` is high, and bits [1:0] as read back stay unchanged.
- R7: `release_on_req` equals bit [5]: 1 selects release-on-request, 0 selects release-on-no-request (fair requester).
- R8: `arb_prio_mode` is 1 (priority scheme) only when bit [4] is 1 and `slot1_strap` is high. Otherwise it is 0 (round robin).
- R9: `arb_level` equals bits [7:6], read as request level 0 to 3 (binary 00 = 0, 11 = 3).
- R10: `reg_rdata` always equals the stored register. The event gating and the strap do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high, clears all bits |
| warm_rst | input | 1 | Warm reset, synchronous, active high, clears bits [3:0] |
| reg_sel | input | 1 | Address decode hit |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored register contents |
| bus_event | input | 1 | External event that masks both window enables |
| slot1_strap | input | 1 | High when this board is the slot-1 controller |
| win32_en | output | 1 | Effective 32-bit window enable |
| epage_en | output | 1 | Effective page window enable |
| disp_en | output | 1 | Display controller enable |
| gpo_n | output | 1 | General-purpose output pin, inverted |
| release_on_req | output | 1 | Bus release mode, 1 = release on request |
| arb_prio_mode | output | 1 | Arbitration scheme, 1 = priority, 0 = round robin |
| arb_level | output | 2 | Arbitration request level |

## Verification
The hardest case to reach is a warm reset that lands on a register whose upper nibble holds non-zero values that differ from the power-on pattern. Only that case shows that the two resets act on different bit subsets. The stimulus therefore writes random values first and then applies warm resets, power-on resets and both at once in random order. Writes that try to clear the sticky display enable are mixed in, and so are toggles of the event and strap inputs while the window and mode bits are set. The readback must stay the same while the outputs change.

// File: rtl/cfg_ctrl_pkg.sv
package cfg_ctrl_pkg;
  localparam int REG_W   = 8;
  localparam int LVL_W   = 2;
  localparam int WARM_HI = 3;   // warm reset clears [WARM_HI:0]
  localparam int B_W32   = 0;
  localparam int B_EPG   = 1;
  localparam int B_DISP  = 2;
  localparam int B_GPO   = 3;
  localparam int B_ARBM  = 4;
  localparam int B_RELM  = 5;
  localparam int B_LVL   = 6;

  typedef enum logic {REL_NO_REQ = 1'b0, REL_ON_REQ = 1'b1} rel_mode_e;
  typedef enum logic {ARB_RR = 1'b0, ARB_PRIO = 1'b1} arb_mode_e;

  // next stored value for a software write, display enable is set-only
  function automatic logic [REG_W-1:0] write_merge(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] wd);
    logic [REG_W-1:0] n;
    n = wd;
    n[B_DISP] = cur[B_DISP] | wd[B_DISP];
    return n;
  endfunction

  // value after a warm reset: the low field is cleared
  function automatic logic [REG_W-1:0] warm_clear(input logic [REG_W-1:0] cur);
    logic [REG_W-1:0] n;
    n = cur;
    n[WARM_HI:0] = '0;
    return n;
  endfunction

  function automatic logic gate_window(input logic stored, input logic evt);
    return stored & ~evt;
  endfunction

  function automatic arb_mode_e eff_arb(input logic bit_m, input logic strap);
    return (bit_m & strap) ? ARB_PRIO : ARB_RR;
  endfunction
endpackage

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfg_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             por_rst,
  input  logic             warm_rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (por_rst)       q_r <= '0;
    else if (warm_rst) q_r <= warm_clear(q_r);
    else if (wr_hit)   q_r <= write_merge(q_r, wdata);
  end

  assign q = q_r;
endmodule

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import cfg_ctrl_pkg::*;
(
  input  logic             [REG_W-1:0] q,
  input  logic                         bus_event,
  input  logic                         slot1_strap,
  output logic                         win32_en,
  output logic                         epage_en,
  output logic                         disp_en,
  output logic                         gpo_n,
  output logic                         release_on_req,
  output logic                         arb_prio_mode,
  output logic             [LVL_W-1:0] arb_level
);
  rel_mode_e rel;
  arb_mode_e arb;

  always_comb begin
    rel = rel_mode_e'(q[B_RELM]);
    arb = eff_arb(q[B_ARBM], slot1_strap);
  end

  assign win32_en       = gate_window(q[B_W32], bus_event);
  assign epage_en       = gate_window(q[B_EPG], bus_event);
  assign disp_en        = q[B_DISP];
  assign gpo_n          = ~q[B_GPO];
  assign release_on_req = (rel == REL_ON_REQ);
  assign arb_prio_mode  = (arb == ARB_PRIO);
  assign arb_level      = q[B_LVL +: LVL_W];
endmodule

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg
  import cfg_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             por_rst,
  input  logic             warm_rst,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             bus_event,
  input  logic             slot1_strap,
  output logic             win32_en,
  output logic             epage_en,
  output logic             disp_en,
  output logic             gpo_n,
  output logic             release_on_req,
  output logic             arb_prio_mode,
  output logic [1:0]       arb_level
);
  logic             wr_hit;
  logic [REG_W-1:0] stored;

  assign wr_hit = reg_sel & reg_wr;

  cfg_reg_store u_store (
    .clk      (clk),
    .por_rst  (por_rst),
    .warm_rst (warm_rst),
    .wr_hit   (wr_hit),
    .wdata    (reg_wdata),
    .q        (stored)
  );

  cfg_reg_decode u_dec (
    .q              (stored),
    .bus_event      (bus_event),
    .slot1_strap    (slot1_strap),
    .win32_en       (win32_en),
    .epage_en       (epage_en),
    .disp_en        (disp_en),
    .gpo_n          (gpo_n),
    .release_on_req (release_on_req),
    .arb_prio_mode  (arb_prio_mode),
    .arb_level      (arb_level)
  );

  assign reg_rdata = stored;
endmodule

// File: rtl/cfg_ctrl_reg_chk.sv
module cfg_ctrl_reg_chk (
  input logic       clk,
  input logic       por_rst,
  input logic       warm_rst,
  input logic       wr_hit,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       bus_event,
  input logic       slot1_strap,
  input logic       win32_en,
  input logic       epage_en,
  input logic       gpo_n,
  input logic       arb_prio_mode
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (por_rst) armed <= 1'b1;

  assert_write_R1: assert property (@(posedge clk) disable iff (!armed)
    (wr_hit && !por_rst && !warm_rst) |=> reg_rdata[7:3] == $past(reg_wdata[7:3]) &&
                                         reg_rdata[1:0] == $past(reg_wdata[1:0]));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!armed)
    (!wr_hit && !por_rst && !warm_rst) |=> $stable(reg_rdata));
  assert_warm_R2: assert property (@(posedge clk) disable iff (!armed)
    (warm_rst && !por_rst) |=> reg_rdata[3:0] == 4'h0 && reg_rdata[7:4] == $past(reg_rdata[7:4]));
  assert_por_R3: assert property (@(posedge clk) disable iff (!armed)
    por_rst |=> reg_rdata == 8'h00);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!armed)
    (reg_rdata[2] && !por_rst && !warm_rst) |=> reg_rdata[2]);
  assert_gpo_R5: assert property (@(posedge clk) disable iff (!armed)
    gpo_n != reg_rdata[3]);
  assert_gate_R6: assert property (@(posedge clk) disable iff (!armed)
    bus_event |-> (!win32_en && !epage_en));
  assert_strap_R8: assert property (@(posedge clk) disable iff (!armed)
    !slot1_strap |-> !arb_prio_mode);
endmodule

bind cfg_ctrl_reg cfg_ctrl_reg_chk u_chk (
  .clk           (clk),
  .por_rst       (por_rst),
  .warm_rst      (warm_rst),
  .wr_hit        (wr_hit),
  .reg_wdata     (reg_wdata),
  .reg_rdata     (reg_rdata),
  .bus_event     (bus_event),
  .slot1_strap   (slot1_strap),
  .win32_en      (win32_en),
  .epage_en      (epage_en),
  .gpo_n         (gpo_n),
  .arb_prio_mode (arb_prio_mode)
);

// File: tb/test_cfg_ctrl_reg.sv
`timescale 1ns/1ps
module test_cfg_ctrl_reg;
  logic       clk = 1'b0;
  logic       por_rst = 1'b0, warm_rst = 1'b0, reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       bus_event = 1'b0, slot1_strap = 1'b0;
  logic [7:0] reg_rdata;
  logic       win32_en, epage_en, disp_en, gpo_n, release_on_req, arb_prio_mode;
  logic [1:0] arb_level;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] mdl = 8'h00;

  always #5 clk = ~clk;

  cfg_ctrl_reg i_cfg_ctrl_reg (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_event(bus_event),
    .slot1_strap(slot1_strap), .win32_en(win32_en), .epage_en(epage_en), .disp_en(disp_en),
    .gpo_n(gpo_n), .release_on_req(release_on_req), .arb_prio_mode(arb_prio_mode),
    .arb_level(arb_level)
  );

  // reference model written from the requirements
  function automatic logic [7:0] predict(input logic [7:0] cur, input logic por, input logic warm,
                                         input logic hit, input logic [7:0] wd);
    if (por)  return 8'h00;                          // R3
    if (warm) return {cur[7:4], 4'h0};               // R2
    if (hit)  return {wd[7:3], cur[2] | wd[2], wd[1:0]}; // R1, R4
    return cur;
  endfunction

  function automatic logic [10:0] expect_outs(input logic [7:0] r, input logic evt, input logic strap);
    // {win32, epage, disp, gpo_n, rel, prio, level[1:0], pad}
    return {r[0] & !evt, r[1] & !evt, r[2], !r[3], r[5], r[4] & strap, r[7:6], 3'b000};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [10:0] e;
    e = expect_outs(mdl, bus_event, slot1_strap);
    check({tag, " R10 readback"}, 32'(reg_rdata), 32'(mdl));
    check({tag, " R6 win32"}, 32'(win32_en), 32'(e[10]));
    check({tag, " R6 epage"}, 32'(epage_en), 32'(e[9]));
    check({tag, " R4 disp"}, 32'(disp_en), 32'(e[8]));
    check({tag, " R5 gpo_n"}, 32'(gpo_n), 32'(e[7]));
    check({tag, " R7 release"}, 32'(release_on_req), 32'(e[6]));
    check({tag, " R8 prio"}, 32'(arb_prio_mode), 32'(e[5]));
    check({tag, " R9 level"}, 32'(arb_level), 32'(e[4:3]));
  endtask

  // drive one cycle at the falling edge, then sample just after the rising edge
  task automatic cycle(input logic por, input logic warm, input logic sel, input logic wr,
                       input logic [7:0] wd, input logic evt, input logic strap, input string tag);
    @(negedge clk);
    por_rst = por; warm_rst = warm; reg_sel = sel; reg_wr = wr; reg_wdata = wd;
    bus_event = evt; slot1_strap = strap;
    mdl = predict(mdl, por, warm, sel & wr, wd);
    @(posedge clk); #1;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    cycle(1, 0, 0, 0, 8'h00, 0, 0, "reset R3");
    cycle(0, 0, 0, 0, 8'h00, 0, 0, "idle");
    // R1: full write, then strobes alone do nothing
    cycle(0, 0, 1, 1, 8'hFF, 0, 1, "write R1");
    cycle(0, 0, 1, 0, 8'h00, 0, 1, "sel only R1");
    cycle(0, 0, 0, 1, 8'h00, 0, 1, "wr only R1");
    // R4: zero write cannot clear display enable
    cycle(0, 0, 1, 1, 8'h00, 0, 1, "clear attempt R4");
    // R6: event masks windows, storage intact
    cycle(0, 0, 1, 1, 8'hA3, 1, 1, "event R6");
    cycle(0, 0, 0, 0, 8'h00, 0, 1, "event off R6");
    // R8: strap low forces round robin
    cycle(0, 0, 1, 1, 8'h10, 0, 0, "strap low R8");
    // R2: warm reset keeps the upper nibble
    cycle(0, 0, 1, 1, 8'hDF, 0, 1, "preload R2");
    cycle(0, 1, 1, 1, 8'h00, 0, 1, "warm R2");
    cycle(0, 0, 0, 0, 8'h00, 0, 1, "after warm R9");
    // R3: power-on wins over warm and write
    cycle(0, 0, 1, 1, 8'h7C, 0, 1, "preload R3");
    cycle(1, 1, 1, 1, 8'hFF, 0, 1, "por+warm R3");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom_range(0, 99);
      cycle(r < 3, (r >= 3 && r < 10), $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
            8'($urandom()), $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, "random");
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule